// File: doc/BRIEF.md
# Instruction-Cache Coordinate Tag Resolver

This block keeps the virtual-address tag store of a small instruction cache, 64 lines of 128 bytes. Inside the pipeline an instruction is named by a compact 12-bit coordinate rather than a full virtual address. The upper 6 bits select the line and the lower 6 bits give the halfword position within that line. When some later stage needs the real address, it sends the coordinate to the resolve port. One cycle later the block returns the line's stored base address with the offset appended, together with the address-space identifier saved for that line.

The refill logic writes tags through a fill port. A fill either installs a base, an ASID and a set valid bit, or it clears the line. Every line has a pin counter. Issue logic pulses pin when an instruction from a line enters flight and pulses unpin when that instruction leaves. A fill aimed at a line whose counter is non-zero is refused. This keeps the coordinates of in-flight instructions resolvable until they retire.

Top module: `icr_coord_resolver`

## Requirements
- R1: After reset every line is invalid and every pin count is zero. `fillReject` and `resDone` are low.
- R2: A fill that is not refused writes base, ASID and valid (`fillInstall`=1) into line `fillIdx` at the clock edge. A resolve issued in a later cycle sees the new contents.
- R3: A resolve with `resReq` high raises `resDone` in the next cycle. For a valid line, `resAddr` = {stored base, offset (`resCoord[5:0]`), 1'b0} and `resAsid` is the stored ASID. The line index is `resCoord[11:6]`. When `resDone` is low, `resAddr` and `resAsid` read zero.
- R4: Resolving a coordinate whose line is invalid sets `resFault` with `resDone`, and drives `resAddr` and `resAsid` to zero.
- R5: A fill to a line whose pin count is non-zero raises `fillReject` combinationally in that same cycle and leaves the line's base, ASID and valid bit unchanged.
- R6: Pin counts are kept per line. A line stays pinned until it has received as many unpins as pins. Pinning one line never blocks fills to another line.
- R7: A pin and an unpin to the same line in the same cycle leave that line's count unchanged.
- R8: A pin to a line whose count is at its maximum (7 by default) is ignored. An unpin to a line whose count is zero is ignored. Counts never wrap.
- R9: When a fill and a resolve address the same line in the same cycle, the resolve returns the contents from before the fill.
- R10: The pin test uses the count at the start of the cycle. A fill in the same cycle as the first pin of an unpinned line is accepted.
- R11: An accepted fill with `fillInstall`=0 invalidates the line, so later resolves of it fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillReq | input | 1 | Fill request for one line |
| fillIdx | input | 6 | Line being filled |
| fillInstall | input | 1 | 1 installs the line, 0 invalidates it |
| fillBase | input | 41 | Line base address, virtual address bits 47:7 |
| fillAsid | input | 16 | Address-space identifier for the line |
| fillReject | output | 1 | Fill refused because the line is pinned |
| pinReq | input | 1 | Increment the pin count of `pinIdx` |
| pinIdx | input | 6 | Line to pin |
| unpinReq | input | 1 | Decrement the pin count of `unpinIdx` |
| unpinIdx | input | 6 | Line to unpin |
| resReq | input | 1 | Resolve request |
| resCoord | input | 12 | Coordinate: {line[5:0], halfword offset[5:0]} |
| resDone | output | 1 | Resolve result valid, one cycle after request |
| resFault | output | 1 | Resolved line was invalid |
| resAddr | output | 48 | Resolved virtual address |
| resAsid | output | 16 | ASID of the resolved line |

## Verification
Two pairs of events can land on one line in the same cycle. The first pair is a fill and a resolve. The second is a fill and the first pin. For the first pair, the bench drives a new tag and a resolve to an already filled line on the same edge. It expects the old base back, and a follow-up resolve must return the new base. For the second pair, fill and pin are driven together on an unpinned line. The bench expects no reject and new contents on resolve, and a second fill to the same line must then be refused.

// File: rtl/icr_pkg.sv
package icr_pkg;
  // Write strobes sent from the pin control to the tag datapath.
  typedef struct packed {
    logic writeEn;   // commit the fill this cycle
    logic setValid;  // value written into the valid bit
  } tagStrobe_t;
endpackage

// File: rtl/icr_pin_ctrl.sv
module icr_pin_ctrl
  import icr_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillReq,
  input  logic             fillInstall,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic             pinReq,
  input  logic [IDX_W-1:0] pinIdx,
  input  logic             unpinReq,
  input  logic [IDX_W-1:0] unpinIdx,
  output logic             fillReject,
  output tagStrobe_t       strobe
);
  localparam int LINES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LINES-1:0] pinnedVec;

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [CNT_W-1:0] cnt;
    logic pinHit;
    logic unpinHit;
    assign pinHit   = pinReq   && (pinIdx   == IDX_W'(g));
    assign unpinHit = unpinReq && (unpinIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (pinHit && !unpinHit && cnt != CNT_MAX) begin
        cnt <= cnt + CNT_W'(1);
      end else if (unpinHit && !pinHit && cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
    assign pinnedVec[g] = |cnt;

    // R7: a balanced pin/unpin leaves the count alone
    a_r7_balanced_pin: assert property (@(posedge clk) disable iff (!rstN)
      (pinHit && unpinHit) |=> $stable(cnt));
    // R8: no wrap at the top
    a_r8_no_wrap_high: assert property (@(posedge clk) disable iff (!rstN)
      (pinHit && !unpinHit && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
    // R8: no wrap at the bottom
    a_r8_no_wrap_low: assert property (@(posedge clk) disable iff (!rstN)
      (unpinHit && !pinHit && cnt == '0) |=> (cnt == '0));
    // R6: a lone pin always leaves the line pinned
    a_r6_pin_holds: assert property (@(posedge clk) disable iff (!rstN)
      (pinHit && !unpinHit) |=> pinnedVec[g]);
  end

  always_comb begin
    fillReject      = fillReq && pinnedVec[fillIdx];
    strobe.writeEn  = fillReq && !pinnedVec[fillIdx];
    strobe.setValid = fillInstall;
  end

  // R5: a write strobe and a refusal never coexist
  a_r5_reject_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    fillReject |-> !strobe.writeEn);
endmodule

// File: rtl/icr_tag_path.sv
module icr_tag_path
  import icr_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 6,
  parameter int ASID_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tagStrobe_t            strobe,
  input  logic [IDX_W-1:0]      wrIdx,
  input  logic [VA_W-OFF_W-2:0] wrBase,
  input  logic [ASID_W-1:0]     wrAsid,
  input  logic                  resReq,
  input  logic [IDX_W+OFF_W-1:0] resCoord,
  output logic                  resDone,
  output logic                  resFault,
  output logic [VA_W-1:0]       resAddr,
  output logic [ASID_W-1:0]     resAsid
);
  localparam int LINES  = 1 << IDX_W;
  localparam int BASE_W = VA_W - OFF_W - 1;

  logic [BASE_W-1:0] baseMem [LINES];
  logic [ASID_W-1:0] asidMem [LINES];
  logic [LINES-1:0]  validVec;

  logic [IDX_W-1:0] lineSel;
  logic [OFF_W-1:0] hwOff;
  assign lineSel = resCoord[IDX_W+OFF_W-1 -: IDX_W];
  assign hwOff   = resCoord[OFF_W-1:0];

  // Tag storage: written on an accepted fill.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      for (int i = 0; i < LINES; i++) begin
        baseMem[i] <= '0;
        asidMem[i] <= '0;
      end
    end else if (strobe.writeEn) begin
      validVec[wrIdx] <= strobe.setValid;
      baseMem[wrIdx]  <= wrBase;
      asidMem[wrIdx]  <= wrAsid;
    end
  end

  // Resolve: read the pre-write contents, register the result.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resDone  <= 1'b0;
      resFault <= 1'b0;
      resAddr  <= '0;
      resAsid  <= '0;
    end else begin
      resDone <= resReq;
      if (resReq && validVec[lineSel]) begin
        resFault <= 1'b0;
        resAddr  <= {baseMem[lineSel], hwOff, 1'b0};
        resAsid  <= asidMem[lineSel];
      end else begin
        resFault <= resReq;
        resAddr  <= '0;
        resAsid  <= '0;
      end
    end
  end

  // R3: a result appears only one cycle after a request
  a_r3_done_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> $past(resReq));
  // R3: resolved addresses are halfword aligned
  a_r3_halfword_aligned: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> (resAddr[0] == 1'b0));
  // R4: a fault carries no address or ASID
  a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    resFault |-> (resDone && resAddr == '0 && resAsid == '0));
  // R2: an installing write leaves the line valid
  a_r2_install_valid: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeEn && strobe.setValid) |=> validVec[$past(wrIdx)]);
endmodule

// File: rtl/icr_coord_resolver.sv
module icr_coord_resolver
  import icr_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 6,
  parameter int ASID_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fillReq,
  input  logic [IDX_W-1:0]        fillIdx,
  input  logic                    fillInstall,
  input  logic [VA_W-OFF_W-2:0]   fillBase,
  input  logic [ASID_W-1:0]       fillAsid,
  output logic                    fillReject,
  input  logic                    pinReq,
  input  logic [IDX_W-1:0]        pinIdx,
  input  logic                    unpinReq,
  input  logic [IDX_W-1:0]        unpinIdx,
  input  logic                    resReq,
  input  logic [IDX_W+OFF_W-1:0]  resCoord,
  output logic                    resDone,
  output logic                    resFault,
  output logic [VA_W-1:0]         resAddr,
  output logic [ASID_W-1:0]       resAsid
);
  tagStrobe_t strobe;

  icr_pin_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .fillReq(fillReq), .fillInstall(fillInstall), .fillIdx(fillIdx),
    .pinReq(pinReq), .pinIdx(pinIdx),
    .unpinReq(unpinReq), .unpinIdx(unpinIdx),
    .fillReject(fillReject), .strobe(strobe)
  );

  icr_tag_path #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ASID_W(ASID_W)) u_path (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wrIdx(fillIdx), .wrBase(fillBase), .wrAsid(fillAsid),
    .resReq(resReq), .resCoord(resCoord),
    .resDone(resDone), .resFault(resFault), .resAddr(resAddr), .resAsid(resAsid)
  );
endmodule

// File: tb/icr_coord_resolver_bench.sv
module icr_coord_resolver_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        fillReq = 1'b0, fillInstall = 1'b0, fillReject;
  logic [5:0]  fillIdx = '0, pinIdx = '0, unpinIdx = '0;
  logic [40:0] fillBase = '0;
  logic [15:0] fillAsid = '0;
  logic        pinReq = 1'b0, unpinReq = 1'b0, resReq = 1'b0;
  logic [11:0] resCoord = '0;
  logic        resDone, resFault;
  logic [47:0] resAddr;
  logic [15:0] resAsid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  icr_coord_resolver u_icr_coord_resolver (
    .clk(clk), .rstN(rstN),
    .fillReq(fillReq), .fillIdx(fillIdx), .fillInstall(fillInstall),
    .fillBase(fillBase), .fillAsid(fillAsid), .fillReject(fillReject),
    .pinReq(pinReq), .pinIdx(pinIdx), .unpinReq(unpinReq), .unpinIdx(unpinIdx),
    .resReq(resReq), .resCoord(resCoord),
    .resDone(resDone), .resFault(resFault), .resAddr(resAddr), .resAsid(resAsid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive a fill for one cycle; check the same-cycle reject.
  task automatic doFill(input logic [5:0] idx, input logic inst, input logic [40:0] base,
                        input logic [15:0] asid, input logic expRej, input string tag);
    @(negedge clk);
    fillReq = 1'b1; fillIdx = idx; fillInstall = inst; fillBase = base; fillAsid = asid;
    #1 check(tag, 64'(fillReject), 64'(expRej));
    @(negedge clk);
    fillReq = 1'b0;
  endtask

  task automatic doPin(input logic p, input logic u, input logic [5:0] idx, input int times);
    for (int k = 0; k < times; k++) begin
      @(negedge clk);
      pinReq = p; unpinReq = u; pinIdx = idx; unpinIdx = idx;
      @(negedge clk);
      pinReq = 1'b0; unpinReq = 1'b0;
    end
  endtask

  // Issue a resolve and check the result on the following cycle.
  task automatic doResolve(input logic [5:0] idx, input logic [5:0] off, input logic expFault,
                           input logic [40:0] base, input logic [15:0] asid, input string tag);
    @(negedge clk);
    resReq = 1'b1; resCoord = {idx, off};
    @(negedge clk);
    resReq = 1'b0;
    check({tag, " done"}, 64'(resDone), 64'd1);
    check({tag, " fault"}, 64'(resFault), 64'(expFault));
    check({tag, " addr"}, 64'(resAddr), expFault ? 64'd0 : 64'({base, off, 1'b0}));
    check({tag, " asid"}, 64'(resAsid), expFault ? 64'd0 : 64'(asid));
  endtask

  task automatic tReset;
    #1;
    check("R1 reject idle", 64'(fillReject), 64'd0);
    check("R1 done idle", 64'(resDone), 64'd0);
    doResolve(6'd5, 6'd1, 1'b1, '0, '0, "R1 invalid after reset");
  endtask

  task automatic tFillResolve;
    doFill(6'd3, 1'b1, 41'h1_2345_6789, 16'hA5A5, 1'b0, "R2 fill line3");
    doResolve(6'd3, 6'd17, 1'b0, 41'h1_2345_6789, 16'hA5A5, "R3 line3 off17");
    doResolve(6'd3, 6'd63, 1'b0, 41'h1_2345_6789, 16'hA5A5, "R3 line3 off63");
    doFill(6'd63, 1'b1, 41'h1FF_FFFF_FFFF, 16'h0042, 1'b0, "R2 fill line63");
    doResolve(6'd63, 6'd0, 1'b0, 41'h1FF_FFFF_FFFF, 16'h0042, "R3 line63 off0");
    @(negedge clk);
    check("R3 idle addr zero", 64'(resAddr), 64'd0);
  endtask

  task automatic tInvalid;
    doResolve(6'd10, 6'd4, 1'b1, '0, '0, "R4 unfilled line10");
    doFill(6'd20, 1'b1, 41'h55, 16'h7, 1'b0, "R11 fill line20");
    doFill(6'd20, 1'b0, 41'h0, 16'h0, 1'b0, "R11 invalidate line20");
    doResolve(6'd20, 6'd2, 1'b1, '0, '0, "R11 line20 faults");
  endtask

  task automatic tPin;
    doFill(6'd7, 1'b1, 41'h777, 16'h0707, 1'b0, "R6 fill line7");
    doPin(1'b1, 1'b0, 6'd7, 2);
    doFill(6'd7, 1'b1, 41'hBAD, 16'hDEAD, 1'b1, "R5 pinned line7 refused");
    doResolve(6'd7, 6'd9, 1'b0, 41'h777, 16'h0707, "R5 line7 unchanged");
    doFill(6'd8, 1'b1, 41'h888, 16'h0808, 1'b0, "R6 other line free");
    doPin(1'b0, 1'b1, 6'd7, 1);
    doFill(6'd7, 1'b1, 41'hBAD, 16'hDEAD, 1'b1, "R6 one unpin short");
    doPin(1'b0, 1'b1, 6'd7, 1);
    doFill(6'd7, 1'b1, 41'h999, 16'h0909, 1'b0, "R6 released");
    doResolve(6'd7, 6'd1, 1'b0, 41'h999, 16'h0909, "R6 refill visible");
  endtask

  task automatic tBalanced;
    doPin(1'b1, 1'b0, 6'd9, 1);
    doPin(1'b1, 1'b1, 6'd9, 1);
    doFill(6'd9, 1'b1, 41'h9, 16'h9, 1'b1, "R7 still pinned");
    doPin(1'b0, 1'b1, 6'd9, 1);
    doFill(6'd9, 1'b1, 41'h9, 16'h9, 1'b0, "R7 freed");
  endtask

  task automatic tSaturate;
    doPin(1'b1, 1'b0, 6'd11, 8);
    doFill(6'd11, 1'b1, 41'h11, 16'h11, 1'b1, "R8 saturated pinned");
    doPin(1'b0, 1'b1, 6'd11, 7);
    doFill(6'd11, 1'b1, 41'h11, 16'h11, 1'b0, "R8 seven unpins free");
    doPin(1'b0, 1'b1, 6'd11, 1);
    doPin(1'b1, 1'b0, 6'd11, 1);
    doFill(6'd11, 1'b1, 41'h12, 16'h12, 1'b1, "R8 unpin at zero ignored");
    doPin(1'b0, 1'b1, 6'd11, 1);
  endtask

  task automatic tFillResolveSame;
    doFill(6'd30, 1'b1, 41'hAAA, 16'h1111, 1'b0, "R9 first fill");
    @(negedge clk);
    fillReq = 1'b1; fillIdx = 6'd30; fillInstall = 1'b1; fillBase = 41'hBBB; fillAsid = 16'h2222;
    resReq = 1'b1; resCoord = {6'd30, 6'd5};
    @(negedge clk);
    fillReq = 1'b0; resReq = 1'b0;
    check("R9 old addr", 64'(resAddr), 64'({41'hAAA, 6'd5, 1'b0}));
    check("R9 old asid", 64'(resAsid), 64'h1111);
    doResolve(6'd30, 6'd5, 1'b0, 41'hBBB, 16'h2222, "R9 new after");
  endtask

  task automatic tFillPinSame;
    @(negedge clk);
    fillReq = 1'b1; fillIdx = 6'd12; fillInstall = 1'b1; fillBase = 41'hC12; fillAsid = 16'h0C0C;
    pinReq = 1'b1; pinIdx = 6'd12;
    #1 check("R10 no reject", 64'(fillReject), 64'd0);
    @(negedge clk);
    fillReq = 1'b0; pinReq = 1'b0;
    doResolve(6'd12, 6'd3, 1'b0, 41'hC12, 16'h0C0C, "R10 fill took effect");
    doFill(6'd12, 1'b1, 41'h0, 16'h0, 1'b1, "R10 now pinned");
    doPin(1'b0, 1'b1, 6'd12, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tFillResolve();
    tInvalid();
    tPin();
    tBalanced();
    tSaturate();
    tFillResolveSame();
    tFillPinSame();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule